// File: doc/BRIEF.md
# 50% Duty Programmable Clock Divider

This block divides a fast input clock by a whole ratio from 1 to 6. The output always spends exactly half of its period high, odd ratios included. For ratios 3 and 5 a half-input-period extension is needed, and the block gets it by re-timing its rising-edge phase signal on the falling input edge and combining the two copies. Ratio 1 is a gated pass-through of the input clock. The ratio is a plain static 3-bit input. Codes 0 and 7 are outside the legal range and act as ratio 1.

The ratio may change while the divider is running. A new code is adopted only at the end of the output period in progress, so no shortened pulse appears. Two mute sources exist: a control bit (active high) and a pin (active low). Either one forces the output low at once and parks the counter. When both mute sources are released, the next input rising edge begins a full new output period. The asynchronous reset also drives the output low.

Top module: `cdiv_duty50`

## Requirements
- R1: For a legal ratio code N (1 to 6, binary on `ratio_code[2:0]`), the output period is N input periods, and every output period begins at an input rising edge with the high phase.
- R2: The output high time is exactly N/2 input periods for every ratio. For odd N (3, 5) the high phase ends on an input falling edge.
- R3: With ratio 1 the output follows the input clock: high in the first half of each input cycle, low in the second.
- R4: Codes 0 and 7 give the same output as ratio 1.
- R5: A code change is adopted only at the first input rising edge after the current output period ends. The period in progress finishes with its old ratio.
- R6: While `mute_cfg` is 1 or `mute_pin_n` is 0, the output is low from the moment mute is applied, and the divider is held at the last count of a period.
- R7: After mute is released, the first input rising edge starts a new output period with the current code.
- R8: While `rst_n` is low the output is low. The first input rising edge after release starts an output period with the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 3 | Divide ratio; 1 to 6 legal, 0 and 7 act as 1 |
| mute_cfg | input | 1 | Mute control bit, active high |
| mute_pin_n | input | 1 | Mute pin, active low |
| clk_out | output | 1 | Divided 50% duty clock |

## Verification
The registered output state changes at an input rising edge, and the falling-edge copy follows half an input period later. The bench therefore samples the output 5 ns after each input edge, once per half cycle, and compares each sample with a half-slot model of the period. Mute acts on the output without delay. A code or mute change counts from the next input rising edge. The bench changes inputs only at the three-quarter point of a cycle, where no check falls, so each expected value is tied to one edge. Duty and period are also timed directly, edge to edge, for ratios 3 and 5.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int RATIO_W   = 3;
  localparam int MAX_RATIO = 6;

  typedef logic [RATIO_W-1:0] ratio_t;

  localparam ratio_t MAX_CODE = ratio_t'(MAX_RATIO);
  localparam ratio_t ONE      = ratio_t'(1);

  // Map any code onto a legal ratio; out-of-range codes fall back to 1.
  function automatic ratio_t legalize(input ratio_t code);
    if (code == '0 || code > MAX_CODE) return ONE;
    return code;
  endfunction
endpackage

// File: rtl/cdiv_period_ctl.sv
module cdiv_period_ctl
  import cdiv_pkg::*;
(
  input  logic   clk_in,
  input  logic   rst_n,
  input  logic   muted,
  input  ratio_t ratio_code,
  output ratio_t cur_n,
  output ratio_t cnt,
  output logic   ph_rise
);
  logic   wrap;
  ratio_t next_n;
  ratio_t next_cnt;

  always_comb begin
    wrap   = (cnt == cur_n - ONE);
    next_n = (muted || wrap) ? legalize(ratio_code) : cur_n;
    if (muted)      next_cnt = next_n - ONE;  // park on last count
    else if (wrap)  next_cnt = '0;
    else            next_cnt = cnt + ONE;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cur_n   <= ONE;
      cnt     <= '0;
      ph_rise <= 1'b0;
    end else begin
      cur_n   <= next_n;
      cnt     <= next_cnt;
      // high for floor(N/2) whole input cycles
      ph_rise <= !muted && (next_cnt < (next_n >> 1));
    end
  end
endmodule

// File: rtl/cdiv_half_shift.sv
module cdiv_half_shift (
  input  logic clk_in,
  input  logic rst_n,
  input  logic ph_rise,
  output logic ph_fall
);
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) ph_fall <= 1'b0;
    else        ph_fall <= ph_rise;
  end
endmodule

// File: rtl/cdiv_out_sel.sv
module cdiv_out_sel
  import cdiv_pkg::*;
(
  input  logic   clk_in,
  input  logic   rst_n,
  input  logic   muted,
  input  ratio_t cur_n,
  input  logic   ph_rise,
  input  logic   ph_fall,
  output logic   clk_out
);
  logic shaped;

  always_comb begin
    if (cur_n == ONE)   shaped = clk_in;
    else if (cur_n[0])  shaped = ph_rise | ph_fall;  // odd: extend by half
    else                shaped = ph_rise;
    clk_out = rst_n & ~muted & shaped;
  end
endmodule

// File: rtl/cdiv_duty50.sv
module cdiv_duty50
  import cdiv_pkg::*;
(
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_code,
  input  logic               mute_cfg,
  input  logic               mute_pin_n,
  output logic               clk_out
);
  logic   muted;
  ratio_t cur_n;
  ratio_t cnt;
  logic   ph_rise;
  logic   ph_fall;

  assign muted = mute_cfg | ~mute_pin_n;

  cdiv_period_ctl u_ctl (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .muted      (muted),
    .ratio_code (ratio_code),
    .cur_n      (cur_n),
    .cnt        (cnt),
    .ph_rise    (ph_rise)
  );

  cdiv_half_shift u_shift (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .ph_rise (ph_rise),
    .ph_fall (ph_fall)
  );

  cdiv_out_sel u_sel (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .muted   (muted),
    .cur_n   (cur_n),
    .ph_rise (ph_rise),
    .ph_fall (ph_fall),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/cdiv_duty50_chk.sv
module cdiv_duty50_chk
  import cdiv_pkg::*;
(
  input logic   clk_in,
  input logic   rst_n,
  input logic   muted,
  input ratio_t cur_n,
  input ratio_t cnt,
  input logic   clk_out
);
  // R1: active ratio legal and count inside it
  a_r1_count_in_range: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cur_n >= ONE) && (cur_n <= MAX_CODE) && (cnt < cur_n));

  // R5: ratio held until the period ends
  a_r5_ratio_held: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!muted && cnt != cur_n - ONE) |=> (cur_n == $past(cur_n)));

  // R6: muted output low at the edge
  a_r6_mute_low: assert property (@(posedge clk_in) disable iff (!rst_n)
    muted |-> !clk_out);

  // R6: muted divider parked on its last count
  a_r6_parked: assert property (@(posedge clk_in) disable iff (!rst_n)
    muted |=> (cnt == cur_n - ONE));

  // R7: a completed (or parked) period restarts at count zero
  a_r7_wrap_to_zero: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!muted && cnt == cur_n - ONE) |=> (cnt == '0));

  // R8: reset holds the output low (checked on falling edges)
  a_r8_reset_low: assert property (@(negedge clk_in)
    !rst_n |-> !clk_out);
endmodule

bind cdiv_duty50 cdiv_duty50_chk u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .muted   (muted),
  .cur_n   (cur_n),
  .cnt     (cnt),
  .clk_out (clk_out)
);

// File: tb/cdiv_duty50_bench.sv
`timescale 1ns/1ps
module cdiv_duty50_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'd1;
  logic       mute_cfg = 1'b0;
  logic       mute_pin_n = 1'b1;
  logic       clk_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int m_n   = 1;
  int m_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  cdiv_duty50 u_cdiv_duty50 (
    .clk_in     (clk),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .mute_cfg   (mute_cfg),
    .mute_pin_n (mute_pin_n),
    .clk_out    (clk_out)
  );

  // vector: {code[2:0], mute_cfg, mute_pin_n, 3'b0, cycles[7:0]}
  localparam int NV = 19;
  localparam logic [15:0] VEC [0:NV-1] = '{
    {3'd1, 1'b0, 1'b1, 3'd0, 8'd10},
    {3'd2, 1'b0, 1'b1, 3'd0, 8'd12},
    {3'd3, 1'b0, 1'b1, 3'd0, 8'd12},
    {3'd4, 1'b0, 1'b1, 3'd0, 8'd12},
    {3'd5, 1'b0, 1'b1, 3'd0, 8'd15},
    {3'd6, 1'b0, 1'b1, 3'd0, 8'd12},
    {3'd0, 1'b0, 1'b1, 3'd0, 8'd6},
    {3'd7, 1'b0, 1'b1, 3'd0, 8'd6},
    {3'd5, 1'b0, 1'b1, 3'd0, 8'd7},
    {3'd2, 1'b0, 1'b1, 3'd0, 8'd8},
    {3'd3, 1'b0, 1'b1, 3'd0, 8'd4},
    {3'd6, 1'b0, 1'b1, 3'd0, 8'd9},
    {3'd3, 1'b1, 1'b1, 3'd0, 8'd5},
    {3'd3, 1'b0, 1'b1, 3'd0, 8'd9},
    {3'd5, 1'b0, 1'b0, 3'd0, 8'd4},
    {3'd5, 1'b0, 1'b1, 3'd0, 8'd10},
    {3'd1, 1'b1, 1'b1, 3'd0, 8'd3},
    {3'd1, 1'b0, 1'b1, 3'd0, 8'd4},
    {3'd4, 1'b0, 1'b1, 3'd0, 8'd8}
  };

  function automatic int legal(input logic [2:0] c);
    if (c == 3'd0 || c == 3'd7) return 1;
    return int'(c);
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: clk_out=%b expected %b", req, $time, got, exp);
    end
  endtask

  // One input cycle: model update at the rising edge, samples at +5 and +15 ns.
  task automatic one_cycle(input string req);
    logic mu, e0, e1;
    @(posedge clk);
    mu = mute_cfg | ~mute_pin_n;
    if (!rst_n) begin
      m_n = 1; m_cnt = 0; e0 = 1'b0; e1 = 1'b0;
    end else begin
      if (mu) begin
        m_n = legal(ratio_code); m_cnt = m_n - 1;
      end else if (m_cnt == m_n - 1) begin
        m_cnt = 0; m_n = legal(ratio_code);
      end else begin
        m_cnt++;
      end
      e0 = !mu && (2*m_cnt < m_n);
      e1 = !mu && (2*m_cnt + 1 < m_n);
    end
    #5  check(req, clk_out, e0);
    #10 check(req, clk_out, e1);
  endtask

  function automatic string tag_of(input int i);
    logic [2:0] c;
    c = VEC[i][15:13];
    if (VEC[i][12] || !VEC[i][11]) return "R6";
    if (i > 0 && (VEC[i-1][12] || !VEC[i-1][11])) return "R7";
    if (c == 3'd0 || c == 3'd7) return "R4";
    if (c == 3'd1) return "R3";
    if (i > 0 && VEC[i-1][15:13] != c) return "R5";
    return c[0] ? "R2" : "R1";
  endfunction

  task automatic measure(input logic [2:0] code, input string req);
    realtime t0, t1, t2;
    ratio_code = code;
    repeat (14) @(posedge clk);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    n_cmp++;
    if ((t1 - t0) < 10.0*code - 0.5 || (t1 - t0) > 10.0*code + 0.5) begin
      n_bad++;
      $display("FAIL %s high time %0t expected %0d ns", req, t1 - t0, 10*code);
    end
    n_cmp++;
    if ((t2 - t0) < 20.0*code - 0.5 || (t2 - t0) > 20.0*code + 0.5) begin
      n_bad++;
      $display("FAIL R1 period %0t expected %0d ns", t2 - t0, 20*code);
    end
  endtask

  initial begin
    // R8: output low under reset
    repeat (3) one_cycle("R8");
    #0 rst_n = 1'b1;  // released at +15 ns of a cycle
    one_cycle("R8");

    for (int i = 0; i < NV; i++) begin
      ratio_code = VEC[i][15:13];
      mute_cfg   = VEC[i][12];
      mute_pin_n = VEC[i][11];
      for (int k = 0; k < int'(VEC[i][7:0]); k++) one_cycle(tag_of(i));
    end

    // R8: reset asserted mid-run, then restart with ratio 3
    ratio_code = 3'd3;
    repeat (4) one_cycle("R2");
    rst_n = 1'b0;
    #1 check("R8", clk_out, 1'b0);
    repeat (2) one_cycle("R8");
    rst_n = 1'b1;
    repeat (7) one_cycle("R8");

    // R2: timed duty and period on the odd ratios, then an even one
    measure(3'd3, "R2");
    measure(3'd5, "R2");
    measure(3'd6, "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired at %0t: done=0 expected 1", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule